// File: doc/BRIEF.md
# Key-Unlocked Clock Control Register

This block holds the 16-bit control word for a clock controller. It records the clock source that is running now, the source to switch to next, a postscaler setting, a low-power oscillator enable and a switch request. It also shows a PLL lock flag and a sticky clock-fail flag. Stray software writes to this word could stop the clock, so each byte lane stays locked. A lane opens only for the one cycle that follows a two-write key sequence aimed at that lane.

The bus side is a plain single-cycle register port. A request is presented with `bus_valid` and always completes in that cycle, so there is no back-pressure and no ready signal. Any request counts as a bus operation for the key sequencers, whatever its address. `bus_rdata` always shows the assembled word. The clock-switch logic outside the block pulses `sw_done` when a switch finishes. The failure detector pulses `fail_det` when it sees a dead clock. The oscillator mux, the PLL and the detector are not part of this block.

Top module: `clkctl_keyreg`

## Requirements
- R1: On reset, the current-source field (bits 14:12) takes `cfg_default_src`, every writable field clears to zero, and `dbg_reject` is 0.
- R2: Writing 0x46 and then 0x57 to the low lane unlocks it. A low-lane write in the next cycle then stores postscaler (bits 7:6), clock-fail flag (bit 3), low-power enable (bit 1) and switch request (bit 0).
- R3: Writing 0x78 and then 0x9A to the high lane unlocks it. A high-lane write in the next cycle then stores the next-source field (bits 10:8).
- R4: The write window is exactly one cycle. A lane write one cycle later is dropped.
- R5: Between the two key writes, any bus request aborts the sequence. This covers a wrong value, a read, a write to another address or a write to the other lane. Cycles with no request keep the sequence armed.
- R6: The two lanes unlock independently. A window on one lane never admits a write to the other lane, even when a single write enables both lanes.
- R7: Bits 14:12 ignore writes. Bits 15, 11, 4 and 2 always read 0.
- R8: A `sw_done` pulse loads the current source from the next-source field and clears the switch request.
- R9: A `fail_det` pulse forces the current source to 001 (fast RC) and sets the clock-fail flag. It wins over a `sw_done` in the same cycle.
- R10: A lane write that is neither an expected key byte nor inside a window sets the sticky `dbg_reject`. Correct key writes do not set it.
- R11: Bit 5 reads the `pll_lock` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on/brown-out reset |
| cfg_default_src | input | 3 | Configured source code loaded at reset |
| bus_valid | input | 1 | Bus request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Request address |
| bus_be | input | 2 | Byte enables, bit 0 low lane, bit 1 high lane |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Current register word |
| pll_lock | input | 1 | PLL lock status |
| sw_done | input | 1 | Clock switch completed pulse |
| fail_det | input | 1 | Clock failure detected pulse |
| cur_src | output | 3 | Current source code |
| nxt_src | output | 3 | Requested next source |
| postscale | output | 2 | Postscaler setting |
| lposc_en | output | 1 | Low-power oscillator enable |
| sw_req | output | 1 | Switch request |
| dbg_reject | output | 1 | Sticky rejected-write flag |

## Verification
The hardest case to reach is a `sw_done` and a `fail_det` landing in the same cycle after a real next source has been programmed. Reaching it takes a full high-lane unlock and a window write first, and then both pulses driven on one edge. Without that setup the override could not be told apart from a switch to the fast-RC code. The broken-sequence cases are also hard to tell from a correct unlock at the ports. Each one ends with a write that would change visible bits if the sequencer had wrongly stayed armed.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int SRC_W = 3;
  localparam int LANES = 2;
  localparam logic [SRC_W-1:0] SRC_FAST_RC = 3'b001;

  typedef enum logic [1:0] {KS_IDLE, KS_ARMED, KS_OPEN} key_st_e;

  function automatic logic [7:0] key_first(input int lane);
    return (lane == 0) ? 8'h46 : 8'h78;
  endfunction

  function automatic logic [7:0] key_second(input int lane);
    return (lane == 0) ? 8'h57 : 8'h9A;
  endfunction
endpackage

// File: rtl/clkctl_key_seq.sv
module clkctl_key_seq
  import clkctl_pkg::*;
#(
  parameter logic [7:0] KEY1 = 8'h00,
  parameter logic [7:0] KEY2 = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_act,
  input  logic       lane_wr,
  input  logic [7:0] lane_byte,
  output logic       win,
  output logic       bad_wr
);
  key_st_e st, st_n;
  logic first_ok, second_ok;

  assign first_ok  = (st == KS_IDLE)  && lane_wr && (lane_byte == KEY1);
  assign second_ok = (st == KS_ARMED) && lane_wr && (lane_byte == KEY2);

  always_comb begin
    st_n = st;
    case (st)
      KS_IDLE:  if (first_ok) st_n = KS_ARMED;
      KS_ARMED: if (bus_act) st_n = second_ok ? KS_OPEN : KS_IDLE;
      default:  st_n = KS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= KS_IDLE;
    else        st <= st_n;

  assign win    = (st == KS_OPEN);
  assign bad_wr = lane_wr && !win && !first_ok && !second_ok;
endmodule

// File: rtl/clkctl_src_track.sv
module clkctl_src_track
  import clkctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] cfg_default_src,
  input  logic             sw_done,
  input  logic             fail_det,
  input  logic [SRC_W-1:0] nxt_src,
  output logic [SRC_W-1:0] cur_src
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        cur_src <= cfg_default_src;
    else if (fail_det) cur_src <= SRC_FAST_RC;
    else if (sw_done)  cur_src <= nxt_src;
endmodule

// File: rtl/clkctl_fields.sv
module clkctl_fields
  import clkctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [7:0]       lo_byte,
  input  logic [7:0]       hi_byte,
  input  logic             sw_done,
  input  logic             fail_det,
  output logic [SRC_W-1:0] nxt_src,
  output logic [1:0]       postscale,
  output logic             clk_fail,
  output logic             lposc_en,
  output logic             sw_req
);
  logic unused_bits;
  assign unused_bits = ^{lo_byte[5:4], lo_byte[2], hi_byte[7:SRC_W]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      nxt_src   <= '0;
      postscale <= '0;
      lposc_en  <= 1'b0;
    end else begin
      if (wr_hi) nxt_src <= hi_byte[SRC_W-1:0];
      if (wr_lo) begin
        postscale <= lo_byte[7:6];
        lposc_en  <= lo_byte[1];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        clk_fail <= 1'b0;
    else if (fail_det) clk_fail <= 1'b1;
    else if (wr_lo)    clk_fail <= lo_byte[3];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       sw_req <= 1'b0;
    else if (sw_done) sw_req <= 1'b0;
    else if (wr_lo)   sw_req <= lo_byte[0];
endmodule

// File: rtl/clkctl_keyreg.sv
module clkctl_keyreg
  import clkctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h74
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_default_src,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_be,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic              pll_lock,
  input  logic              sw_done,
  input  logic              fail_det,
  output logic [2:0]        cur_src,
  output logic [2:0]        nxt_src,
  output logic [1:0]        postscale,
  output logic              lposc_en,
  output logic              sw_req,
  output logic              dbg_reject
);
  logic [LANES-1:0] lane_wr, win, bad_wr, commit;
  logic             clk_fail;
  logic             reg_wr;

  assign reg_wr = bus_valid && bus_we && (bus_addr == REG_ADDR);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_wr[l] = reg_wr && bus_be[l];
    assign commit[l]  = lane_wr[l] && win[l];
    clkctl_key_seq #(.KEY1(key_first(l)), .KEY2(key_second(l))) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_act  (bus_valid),
      .lane_wr  (lane_wr[l]),
      .lane_byte(bus_wdata[8*l +: 8]),
      .win      (win[l]),
      .bad_wr   (bad_wr[l])
    );
  end

  clkctl_fields u_fields (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_lo    (commit[0]),
    .wr_hi    (commit[1]),
    .lo_byte  (bus_wdata[7:0]),
    .hi_byte  (bus_wdata[15:8]),
    .sw_done  (sw_done),
    .fail_det (fail_det),
    .nxt_src  (nxt_src),
    .postscale(postscale),
    .clk_fail (clk_fail),
    .lposc_en (lposc_en),
    .sw_req   (sw_req)
  );

  clkctl_src_track u_src (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_default_src(cfg_default_src),
    .sw_done        (sw_done),
    .fail_det       (fail_det),
    .nxt_src        (nxt_src),
    .cur_src        (cur_src)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       dbg_reject <= 1'b0;
    else if (|bad_wr) dbg_reject <= 1'b1;

  assign bus_rdata = {1'b0, cur_src, 1'b0, nxt_src, postscale, pll_lock,
                      1'b0, clk_fail, 1'b0, lposc_en, sw_req};
endmodule

// File: rtl/clkctl_keyreg_chk.sv
module clkctl_keyreg_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h74
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_be,
  input logic [15:0]       bus_wdata,
  input logic [15:0]       bus_rdata,
  input logic              pll_lock,
  input logic              sw_done,
  input logic              fail_det,
  input logic [2:0]        cur_src,
  input logic [2:0]        nxt_src,
  input logic              dbg_reject,
  input logic [1:0]        win
);
  logic reg_wr;
  assign reg_wr = bus_valid && bus_we && (bus_addr == REG_ADDR);

  assert_lo_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    win[0] |-> $past(reg_wr && bus_be[0] && bus_wdata[7:0] == 8'h57));
  assert_hi_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
    win[1] |-> $past(reg_wr && bus_be[1] && bus_wdata[15:8] == 8'h9A));
  assert_lo_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    win[0] |=> !win[0]);
  assert_hi_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    win[1] |=> !win[1]);
  assert_unimpl_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rdata[15] && !bus_rdata[11] && !bus_rdata[4] && !bus_rdata[2]);
  assert_cur_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_done && !fail_det) |=> $stable(cur_src));
  assert_switch_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_done && !fail_det) |=> (cur_src == $past(nxt_src)) && !bus_rdata[0]);
  assert_fail_override_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fail_det |=> (cur_src == 3'b001) && bus_rdata[3]);
  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_reject |=> dbg_reject);
  assert_lock_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[5] == pll_lock);
endmodule

bind clkctl_keyreg clkctl_keyreg_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_be    (bus_be),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pll_lock  (pll_lock),
  .sw_done   (sw_done),
  .fail_det  (fail_det),
  .cur_src   (cur_src),
  .nxt_src   (nxt_src),
  .dbg_reject(dbg_reject),
  .win       (win)
);

// File: tb/tb_clkctl_keyreg.sv
`timescale 1ns/1ps
module tb_clkctl_keyreg;
  localparam logic [7:0] REG   = 8'h74;
  localparam logic [7:0] OTHER = 8'h10;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [2:0]  cfg_default_src = 3'b011;
  logic        bus_valid = 0, bus_we = 0, pll_lock = 0, sw_done = 0, fail_det = 0;
  logic [7:0]  bus_addr = 0;
  logic [1:0]  bus_be = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic [2:0]  cur_src, nxt_src;
  logic [1:0]  postscale;
  logic        lposc_en, sw_req, dbg_reject;

  int checks = 0, failures = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  clkctl_keyreg dut (
    .clk(clk), .rst_n(rst_n), .cfg_default_src(cfg_default_src),
    .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pll_lock(pll_lock),
    .sw_done(sw_done), .fail_det(fail_det), .cur_src(cur_src), .nxt_src(nxt_src),
    .postscale(postscale), .lposc_en(lposc_en), .sw_req(sw_req), .dbg_reject(dbg_reject)
  );

  task automatic wr(input logic [7:0] a, input logic [1:0] be, input logic [15:0] d);
    bus_valid = 1; bus_we = 1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_we = 0; bus_be = 0; bus_wdata = 0; bus_addr = 0;
  endtask

  task automatic rd();
    bus_valid = 1; bus_we = 0; bus_addr = REG;
    @(negedge clk);
    bus_valid = 0; bus_addr = 0;
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic done, input logic fail);
    sw_done = done; fail_det = fail;
    @(negedge clk);
    sw_done = 0; fail_det = 0;
  endtask

  task automatic expect_reg(input logic [15:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic chk_dbg(input logic e, input string tag);
    #1;
    checks++;
    if (dbg_reject !== e) begin
      failures++;
      $display("FAIL %s dbg_reject=%b expected=%b", tag, dbg_reject, e);
    end
  endtask

  // monitor: compares the register word against queued expectations
  initial begin
    logic [15:0] e;
    string t;
    forever begin
      @(negedge clk);
      #2;
      while (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (bus_rdata !== e) begin
          failures++;
          $display("FAIL %s rdata=%h expected=%h", t, bus_rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    gap(2);
    rst_n = 1;
    gap(1);
    expect_reg(16'h3000, "R1 reset word");
    chk_dbg(1'b0, "R1 reset reject flag");
    gap(1);
    pll_lock = 1;
    gap(1);
    expect_reg(16'h3020, "R11 lock set");
    gap(1);
    pll_lock = 0;
    gap(1);
    expect_reg(16'h3000, "R11 lock clear");

    // R2: low unlock then window write; R7 bits 5,4,2 stay zero
    wr(REG, 2'b01, 16'h0046); wr(REG, 2'b01, 16'h0057); wr(REG, 2'b01, 16'h00FF);
    expect_reg(16'h30CB, "R2 low window write");
    chk_dbg(1'b0, "R10 key writes not rejected");
    // R3: high unlock; R7 current source ignores write
    wr(REG, 2'b10, 16'h7800); wr(REG, 2'b10, 16'h9A00); wr(REG, 2'b10, 16'hFF00);
    expect_reg(16'h37CB, "R3 R7 high window write");
    gap(1);
    // R8 switch complete
    pulse(1'b1, 1'b0);
    expect_reg(16'h77CA, "R8 switch loads next source");
    // R4 late write
    wr(REG, 2'b01, 16'h0046); wr(REG, 2'b01, 16'h0057); gap(1); wr(REG, 2'b01, 16'h0000);
    expect_reg(16'h77CA, "R4 late write dropped");
    chk_dbg(1'b1, "R10 late write flagged");
    // R5 broken sequences
    wr(REG, 2'b01, 16'h0046); rd(); wr(REG, 2'b01, 16'h0057); wr(REG, 2'b01, 16'h0000);
    expect_reg(16'h77CA, "R5 read aborts");
    gap(1);
    wr(REG, 2'b01, 16'h0046); wr(REG, 2'b01, 16'h0055); wr(REG, 2'b01, 16'h0057); wr(REG, 2'b01, 16'h0000);
    expect_reg(16'h77CA, "R5 wrong value aborts");
    gap(1);
    wr(REG, 2'b01, 16'h0046); wr(OTHER, 2'b01, 16'h0000); wr(REG, 2'b01, 16'h0057); wr(REG, 2'b01, 16'h0000);
    expect_reg(16'h77CA, "R5 other address aborts");
    gap(1);
    wr(REG, 2'b01, 16'h0046); wr(REG, 2'b10, 16'h7800); wr(REG, 2'b01, 16'h0057); wr(REG, 2'b01, 16'h0000);
    expect_reg(16'h77CA, "R5 other lane aborts");
    gap(1);
    wr(REG, 2'b01, 16'h0046); gap(1); wr(REG, 2'b01, 16'h0057); wr(REG, 2'b01, 16'h0000);
    expect_reg(16'h7700, "R5 idle gap keeps sequence");
    gap(1);
    // R6 independence
    wr(REG, 2'b10, 16'h7800); wr(REG, 2'b10, 16'h9A00); wr(REG, 2'b01, 16'h00FF);
    expect_reg(16'h7700, "R6 high window rejects low write");
    gap(1);
    wr(REG, 2'b01, 16'h0046); wr(REG, 2'b01, 16'h0057); wr(REG, 2'b11, 16'hFFFF);
    expect_reg(16'h77CB, "R6 dual-lane write only low accepted");
    gap(1);
    // R9 fail overrides switch
    wr(REG, 2'b10, 16'h7800); wr(REG, 2'b10, 16'h9A00); wr(REG, 2'b10, 16'h0200);
    expect_reg(16'h72CB, "R3 next source 010");
    gap(1);
    pulse(1'b1, 1'b1);
    expect_reg(16'h12CA, "R9 fail beats switch");
    gap(1);
    pulse(1'b1, 1'b0);
    expect_reg(16'h22CA, "R8 switch to 010");
    wr(REG, 2'b01, 16'h0046); wr(REG, 2'b01, 16'h0057); wr(REG, 2'b01, 16'h0000);
    expect_reg(16'h2200, "R2 clear fail flag");
    gap(1);
    pulse(1'b0, 1'b1);
    expect_reg(16'h1208, "R9 fail alone");
    gap(1);
    // R1 second reset with another default
    rst_n = 0; cfg_default_src = 3'b111;
    gap(1);
    rst_n = 1;
    gap(1);
    expect_reg(16'h7000, "R1 reset to PLL default");
    chk_dbg(1'b0, "R1 reject flag cleared");
    gap(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule